// File: doc/BRIEF.md
# EEPROM Command and Status Register

This block is the command and status word that sits in front of a serial EEPROM controller. Two bus masters can write it: a network-side master and a local master. One input selects which of the two owns the EEPROM. The owner starts read, write and reload operations by writing a command code. The block checks the code and gates writes through a write-enable bit. It hands valid operations to an EEPROM engine over a one-cycle request, a done pulse and an acknowledge-error flag. It latches errors, tracks the running command and busy state, and reports the configuration-area load and checksum status.

An emulation mode can be selected. In that mode no request goes to the engine. The local master reads the pending command from the register, performs the work itself, and signals completion by writing the same command code back. It can also raise the error flag to report a temporary failure. Both masters read the same status word.

Top module: `eeprom_cmd_csr`

## Requirements
- R1: After reset the write-enable bit (bit 0), the command field (bits 3:1), busy (bit 4) and error (bit 5) read 0, and the not-loaded bit (bit 10) reads 1.
- R2: When the owner writes a start code and busy is 0, the block does three things. Busy becomes 1, the command field holds the code, and, outside emulation, `eng_req` is high for exactly one cycle with `eng_cmd` equal to the code. The start codes are 001 read, 100 reload, and 010 write when writing is enabled. The owner is the local master when `loc_owns` is 1 and the network master otherwise.
- R3: While busy is 1, every command write is ignored and the command field keeps its value.
- R4: An owner write of a reserved code (011, 101, 110, 111) while idle sets the error bit and starts nothing.
- R5: An owner write of the idle code 000 while idle clears the error bit. If a set condition occurs in the same cycle, the set takes priority.
- R6: An owner write of code 010 while the effective write enable is 0 sets the error bit, leaves busy at 0 and raises no `eng_req`.
- R7: The write-enable bit reads 1 whenever `loc_owns` is 1. Otherwise it holds the value of bit 0 from the latest network write.
- R8: Outside emulation, an `eng_done` pulse while busy clears busy and returns the command field to 000. If `eng_ack_err` is 1 in that cycle, the error bit is set.
- R9: The not-loaded bit clears when a reload completes without error. It never rises again before the next reset.
- R10: In emulation (bit 6 = 1), no `eng_req` is raised and `eng_done` is ignored. A local write whose command field equals the running command completes the operation.
- R11: In emulation, a local write with bit 5 set sets the error bit.
- R12: Bits 15:11 read 0. Command writes from the non-owner and network writes while the local master owns control change nothing.
- R13: Bit 7 reflects `cfg_burst8` (1 means 8-byte reads), bit 8 reflects `cfg_addr2` (1 means two address bytes), and bit 9 reflects `rld_csum_err`. All three follow their inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_owns | input | 1 | Local master owns EEPROM control |
| cfg_emul | input | 1 | Emulation mode select |
| cfg_burst8 | input | 1 | Read burst size strap |
| cfg_addr2 | input | 1 | Address byte count strap |
| net_wr | input | 1 | Network master write strobe |
| net_wdata | input | DATA_W | Network master write data |
| loc_wr | input | 1 | Local master write strobe |
| loc_wdata | input | DATA_W | Local master write data |
| csr_rdata | output | DATA_W | Status word seen by both masters |
| eng_req | output | 1 | One-cycle request to the EEPROM engine |
| eng_cmd | output | 3 | Command for the engine, valid with eng_req |
| eng_done | input | 1 | Engine completion pulse |
| eng_ack_err | input | 1 | Engine reports a missing acknowledge, valid with eng_done |
| rld_csum_err | input | 1 | Checksum error from the reload logic |

## Verification
Every state bit of this block is visible in the status word one cycle after the edge that changes it. A busy flag stuck at 1 or cleared too early therefore shows at once as a wrong command field, or as a new command that starts or fails to start. A wrongly latched error or not-loaded bit shows on the next read. A request pulse that is missing, repeated or sent in emulation shows on `eng_req` in the cycle after the owner's write. For this reason the bench compares every field of the word and the request port in every cycle against its own model.

// File: rtl/ee_csr_pkg.sv
package ee_csr_pkg;

   localparam int CMD_W = 3;

   typedef enum logic [CMD_W-1:0] {
      CMD_IDLE   = 3'b000,
      CMD_READ   = 3'b001,
      CMD_WRITE  = 3'b010,
      CMD_RELOAD = 3'b100
   } ee_cmd_e;

   // status word layout
   localparam int WE_BIT    = 0;
   localparam int CMD_LSB   = 1;
   localparam int BUSY_BIT  = CMD_LSB + CMD_W;
   localparam int ERR_BIT   = BUSY_BIT + 1;
   localparam int EMUL_BIT  = ERR_BIT + 1;
   localparam int BURST_BIT = EMUL_BIT + 1;
   localparam int ADDR_BIT  = BURST_BIT + 1;
   localparam int CSUM_BIT  = ADDR_BIT + 1;
   localparam int NLD_BIT   = CSUM_BIT + 1;
   localparam int USED_W    = NLD_BIT + 1;

   typedef struct packed {
      logic is_idle;
      logic is_start;
      logic is_reject;
   } cmd_class_t;

endpackage

// File: rtl/ee_cmd_decode.sv
module ee_cmd_decode
   import ee_csr_pkg::*;
(
   input  logic [CMD_W-1:0] code,
   input  logic             we_eff,
   output cmd_class_t       cls
);

   always_comb begin
      cls = '0;
      unique case (code)
         CMD_IDLE:             cls.is_idle   = 1'b1;
         CMD_READ, CMD_RELOAD: cls.is_start  = 1'b1;
         CMD_WRITE: begin
            cls.is_start  = we_eff;
            cls.is_reject = ~we_eff;
         end
         default:              cls.is_reject = 1'b1;
      endcase
   end

endmodule

// File: rtl/ee_cmd_seq.sv
module ee_cmd_seq
   import ee_csr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic             start,
   input  logic [CMD_W-1:0] code,
   input  logic             emul,
   input  logic             eng_done,
   input  logic             emu_wr,
   input  logic [CMD_W-1:0] emu_code,
   output logic             busy,
   output logic [CMD_W-1:0] cmd_cur,
   output logic             req,
   output logic             finish,
   output logic             finish_reload
);

   logic             busy_q, req_q;
   logic [CMD_W-1:0] cmd_q;
   logic             emu_match;

   assign emu_match     = emu_wr && (emu_code == cmd_q);
   assign finish        = busy_q && (emul ? emu_match : eng_done);
   assign finish_reload = finish && (cmd_q == CMD_RELOAD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cmd_q  <= CMD_IDLE;
         req_q  <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (!busy_q) begin
            if (issue && start) begin
               busy_q <= 1'b1;
               cmd_q  <= code;
               req_q  <= ~emul;
            end
         end else if (finish) begin
            busy_q <= 1'b0;
            cmd_q  <= CMD_IDLE;
         end
      end
   end

   assign busy    = busy_q;
   assign cmd_cur = cmd_q;
   assign req     = req_q;

endmodule

// File: rtl/ee_flag_reg.sv
module ee_flag_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic we_wr,
   input  logic we_val,
   input  logic err_set,
   input  logic err_clr,
   input  logic nld_clr,
   output logic we_q,
   output logic err_q,
   output logic nld_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_q  <= 1'b0;
         err_q <= 1'b0;
         nld_q <= 1'b1;
      end else begin
         if (we_wr)        we_q  <= we_val;
         if (err_set)      err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
         if (nld_clr)      nld_q <= 1'b0;
      end
   end

endmodule

// File: rtl/eeprom_cmd_csr.sv
module eeprom_cmd_csr
   import ee_csr_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter bit HAS_EMUL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loc_owns,
   input  logic              cfg_emul,
   input  logic              cfg_burst8,
   input  logic              cfg_addr2,
   input  logic              net_wr,
   input  logic [DATA_W-1:0] net_wdata,
   input  logic              loc_wr,
   input  logic [DATA_W-1:0] loc_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   output logic              eng_req,
   output logic [CMD_W-1:0]  eng_cmd,
   input  logic              eng_done,
   input  logic              eng_ack_err,
   input  logic              rld_csum_err
);

   localparam int PAD_W = DATA_W - USED_W;

   if (DATA_W < USED_W) begin : g_chk_w
      $error("DATA_W too small for the status layout");
   end

   logic emul_on;
   if (HAS_EMUL) begin : g_emul
      assign emul_on = cfg_emul;
   end else begin : g_noemul
      assign emul_on = 1'b0;
   end

   // owner selection
   logic             own_wr;
   logic [CMD_W-1:0] own_code;
   assign own_wr   = loc_owns ? loc_wr : net_wr;
   assign own_code = loc_owns ? loc_wdata[CMD_LSB +: CMD_W]
                              : net_wdata[CMD_LSB +: CMD_W];

   logic we_q, we_eff, err_q, nld_q;
   assign we_eff = loc_owns | we_q;

   cmd_class_t cls;
   ee_cmd_decode u_dec (
      .code   (own_code),
      .we_eff (we_eff),
      .cls    (cls)
   );

   logic             busy, req, finish, finish_reload;
   logic [CMD_W-1:0] cmd_cur;
   logic             issue;
   assign issue = own_wr & ~busy;

   ee_cmd_seq u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .issue         (issue),
      .start         (cls.is_start),
      .code          (own_code),
      .emul          (emul_on),
      .eng_done      (eng_done),
      .emu_wr        (loc_wr),
      .emu_code      (loc_wdata[CMD_LSB +: CMD_W]),
      .busy          (busy),
      .cmd_cur       (cmd_cur),
      .req           (req),
      .finish        (finish),
      .finish_reload (finish_reload)
   );

   logic emu_err, fin_err, err_set, err_clr, nld_clr;
   assign emu_err = emul_on & loc_wr & loc_wdata[ERR_BIT];
   assign fin_err = emul_on ? emu_err : eng_ack_err;
   assign err_set = (issue & cls.is_reject) | (finish & fin_err) | emu_err;
   assign err_clr = issue & cls.is_idle;
   assign nld_clr = finish_reload & ~fin_err;

   ee_flag_reg u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_wr   (net_wr & ~loc_owns),
      .we_val  (net_wdata[WE_BIT]),
      .err_set (err_set),
      .err_clr (err_clr),
      .nld_clr (nld_clr),
      .we_q    (we_q),
      .err_q   (err_q),
      .nld_q   (nld_q)
   );

   logic [USED_W-1:0] word;
   always_comb begin
      word                      = '0;
      word[WE_BIT]              = we_eff;
      word[CMD_LSB +: CMD_W]    = cmd_cur;
      word[BUSY_BIT]            = busy;
      word[ERR_BIT]             = err_q;
      word[EMUL_BIT]            = emul_on;
      word[BURST_BIT]           = cfg_burst8;
      word[ADDR_BIT]            = cfg_addr2;
      word[CSUM_BIT]            = rld_csum_err;
      word[NLD_BIT]             = nld_q;
   end

   if (PAD_W > 0) begin : g_pad
      assign csr_rdata = {{PAD_W{1'b0}}, word};
   end else begin : g_nopad
      assign csr_rdata = word;
   end

   assign eng_req = req;
   assign eng_cmd = cmd_cur;

endmodule

// File: rtl/ee_csr_checker.sv
module ee_csr_checker
   import ee_csr_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              loc_owns,
   input logic              emul_on,
   input logic              net_wr,
   input logic [DATA_W-1:0] net_wdata,
   input logic              loc_wr,
   input logic [DATA_W-1:0] loc_wdata,
   input logic [DATA_W-1:0] csr_rdata,
   input logic              eng_req,
   input logic              eng_done
);

   logic             o_wr, o_bad;
   logic [CMD_W-1:0] o_code;
   assign o_wr   = loc_owns ? loc_wr : net_wr;
   assign o_code = loc_owns ? loc_wdata[CMD_LSB +: CMD_W] : net_wdata[CMD_LSB +: CMD_W];
   assign o_bad  = !(o_code inside {CMD_IDLE, CMD_READ, CMD_WRITE, CMD_RELOAD});

   assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |-> csr_rdata[BUSY_BIT]);

   assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |=> !eng_req);

   assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rdata[BUSY_BIT] && !eng_done && !loc_wr)
      |=> (csr_rdata[BUSY_BIT] && $stable(csr_rdata[CMD_LSB +: CMD_W])));

   assert_invalid_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (o_wr && o_bad && !csr_rdata[BUSY_BIT]) |=> csr_rdata[ERR_BIT]);

   assert_we_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
      loc_owns |-> csr_rdata[WE_BIT]);

   assert_nld_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_rdata[NLD_BIT] |=> !csr_rdata[NLD_BIT]);

   assert_emul_noreq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |-> !$past(emul_on));

endmodule

bind eeprom_cmd_csr ee_csr_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .loc_owns  (loc_owns),
   .emul_on   (emul_on),
   .net_wr    (net_wr),
   .net_wdata (net_wdata),
   .loc_wr    (loc_wr),
   .loc_wdata (loc_wdata),
   .csr_rdata (csr_rdata),
   .eng_req   (eng_req),
   .eng_done  (eng_done)
);

// File: tb/test_eeprom_cmd_csr.sv
`timescale 1ns/1ps
module test_eeprom_cmd_csr;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          loc_owns = 0, cfg_emul = 0, cfg_burst8 = 0, cfg_addr2 = 0;
   logic          net_wr = 0, loc_wr = 0;
   logic [DW-1:0] net_wdata = '0, loc_wdata = '0;
   logic [DW-1:0] csr_rdata;
   logic          eng_req;
   logic [2:0]    eng_cmd;
   logic          eng_done = 0, eng_ack_err = 0, rld_csum_err = 0;

   always #2 clk = ~clk;

   eeprom_cmd_csr #(.DATA_W(DW)) i_eeprom_cmd_csr (
      .clk(clk), .rst_n(rst_n), .loc_owns(loc_owns), .cfg_emul(cfg_emul),
      .cfg_burst8(cfg_burst8), .cfg_addr2(cfg_addr2),
      .net_wr(net_wr), .net_wdata(net_wdata), .loc_wr(loc_wr), .loc_wdata(loc_wdata),
      .csr_rdata(csr_rdata), .eng_req(eng_req), .eng_cmd(eng_cmd),
      .eng_done(eng_done), .eng_ack_err(eng_ack_err), .rld_csum_err(rld_csum_err)
   );

   int n_chk = 0, n_err = 0;
   bit chk_on = 0;

   // reference model state
   bit       m_we, m_busy, m_err, m_nld, m_req;
   bit [2:0] m_cmd;

   task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_we = 0; m_busy = 0; m_err = 0; m_nld = 1; m_req = 0; m_cmd = 0;
      end else begin
         bit o_wr, we_eff, fin, ferr, set_e, clr_e;
         bit [2:0] code;
         bit n_busy, n_req, n_nld, n_we;
         bit [2:0] n_cmd;
         o_wr   = loc_owns ? loc_wr : net_wr;
         code   = loc_owns ? loc_wdata[3:1] : net_wdata[3:1];
         we_eff = loc_owns | m_we;
         n_busy = m_busy; n_cmd = m_cmd; n_req = 0; n_nld = m_nld; n_we = m_we;
         set_e = 0; clr_e = 0;
         if (net_wr && !loc_owns) n_we = net_wdata[0];
         fin  = m_busy && (cfg_emul ? (loc_wr && loc_wdata[3:1] == m_cmd) : eng_done);
         ferr = cfg_emul ? (loc_wr && loc_wdata[5]) : eng_ack_err;
         if (!m_busy && o_wr) begin
            case (code)
               3'd0: clr_e = 1;
               3'd1, 3'd4: begin n_busy = 1; n_cmd = code; n_req = !cfg_emul; end
               3'd2: if (we_eff) begin n_busy = 1; n_cmd = code; n_req = !cfg_emul; end
                     else set_e = 1;
               default: set_e = 1;
            endcase
         end
         if (fin) begin
            n_busy = 0; n_cmd = 0;
            if (ferr) set_e = 1;
            if (m_cmd == 3'd4 && !ferr) n_nld = 0;
         end
         if (cfg_emul && loc_wr && loc_wdata[5]) set_e = 1;
         if (set_e) m_err = 1; else if (clr_e) m_err = 0;
         m_busy = n_busy; m_cmd = n_cmd; m_req = n_req; m_nld = n_nld; m_we = n_we;
      end
   end

   // per-cycle comparison of every field, away from the active edge
   always @(negedge clk) if (chk_on) begin
      cmp("R7 write enable", 16'(csr_rdata[0]), 16'(loc_owns | m_we));
      cmp("R2 command field", 16'(csr_rdata[3:1]), 16'(m_cmd));
      cmp("R3 busy", 16'(csr_rdata[4]), 16'(m_busy));
      cmp("R4 error", 16'(csr_rdata[5]), 16'(m_err));
      cmp("R13 status straps", 16'(csr_rdata[9:6]),
          16'({rld_csum_err, cfg_addr2, cfg_burst8, cfg_emul}));
      cmp("R9 not loaded", 16'(csr_rdata[10]), 16'(m_nld));
      cmp("R12 reserved", 16'(csr_rdata[15:11]), 16'd0);
      cmp("R10 engine request", 16'(eng_req), 16'(m_req));
      if (m_req) cmp("R2 engine command", 16'(eng_cmd), 16'(m_cmd));
   end

   task automatic idle_in();
      net_wr = 0; loc_wr = 0; eng_done = 0; eng_ack_err = 0;
   endtask

   task automatic tick();
      @(posedge clk); #1;
      idle_in();
   endtask

   task automatic net_w(logic [15:0] d);
      net_wr = 1; net_wdata = d; tick();
   endtask

   task automatic loc_w(logic [15:0] d);
      loc_wr = 1; loc_wdata = d; tick();
   endtask

   task automatic done(bit ae);
      eng_done = 1; eng_ack_err = ae; tick();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #400000;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finish");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      cfg_burst8 = 1; cfg_addr2 = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #1;
      // R1 R13 reset word: only not-loaded and burst strap set
      cmp("R1 reset word", csr_rdata, 16'h0480);
      chk_on = 1;

      // network owns, normal mode
      net_w(16'h0004);                              // write cmd with we=0
      cmp("R6 blocked write busy", 16'(csr_rdata[4]), 16'd0);
      cmp("R6 blocked write error", 16'(csr_rdata[5]), 16'd1);
      net_w(16'h0000);                              // idle clears error
      cmp("R5 idle clears error", 16'(csr_rdata[5]), 16'd0);
      net_w(16'h0001);
      net_w(16'h0005);                              // we + write cmd
      cmp("R2 request pulse", 16'(eng_req), 16'd1);
      cmp("R2 request command", 16'(eng_cmd), 16'd2);
      tick();
      cmp("R2 single pulse", 16'(eng_req), 16'd0);
      net_w(16'h0003);                              // read while busy
      cmp("R3 ignored while busy", 16'(csr_rdata[3:1]), 16'd2);
      done(1);
      cmp("R8 done clears busy", 16'(csr_rdata[4:1]), 16'd0);
      cmp("R8 ack error latched", 16'(csr_rdata[5]), 16'd1);
      net_w(16'h0001);
      net_w(16'h0009);                              // reload
      tick();
      done(0);
      cmp("R9 reload clears not loaded", 16'(csr_rdata[10]), 16'd0);
      net_w(16'h0000);
      net_w(16'h0007);                              // reserved code 011
      cmp("R4 invalid code error", 16'(csr_rdata[5:4]), 16'b10);

      // local owns, emulation
      net_w(16'h0000);
      loc_owns = 1; cfg_emul = 1;
      loc_w(16'h0000);                              // clear error
      net_w(16'h0002);                              // non-owner command
      cmp("R12 non-owner ignored", 16'(csr_rdata[4]), 16'd0);
      cmp("R7 owner forces we", 16'(csr_rdata[0]), 16'd1);
      loc_w(16'h0002);                              // read
      cmp("R10 emul no request", 16'(eng_req), 16'd0);
      done(0);
      cmp("R10 done ignored in emul", 16'(csr_rdata[4]), 16'd1);
      loc_w(16'h0002);                              // completion
      cmp("R10 completion write", 16'(csr_rdata[4]), 16'd0);
      loc_w(16'h0020);
      cmp("R11 emul error flag", 16'(csr_rdata[5]), 16'd1);

      // constrained random phases
      for (int ph = 0; ph < 8; ph++) begin
         loc_owns   = ph[0];
         cfg_emul   = ph[1];
         cfg_addr2  = ph[2];
         cfg_burst8 = $urandom % 2;
         for (int i = 0; i < 1500; i++) begin
            rld_csum_err = ($urandom % 16 == 0);
            net_wr    = ($urandom % 4 == 0);
            net_wdata = 16'($urandom);
            loc_wr    = ($urandom % 4 == 0);
            loc_wdata = 16'($urandom) & 16'hFFDF;
            if ($urandom % 6 == 0) loc_wdata[5] = 1'b1;
            if (m_busy && ($urandom % 2 == 0)) loc_wdata[3:1] = m_cmd;
            eng_done    = ($urandom % 5 == 0);
            eng_ack_err = ($urandom % 4 == 0);
            @(posedge clk); #1;
         end
         idle_in();
         @(posedge clk); #1;
      end
      summary();
   end

endmodule